// File: doc/BRIEF.md
# Subroutine-Call Bus Cycle Sequencer

This block produces the bus cycles of an absolute subroutine call on an 8-bit CPU with a 16-bit address space, where a memory access takes place on every clock. After a synchronous reset it holds a program counter and an 8-bit stack pointer, both loaded from inputs. It reads an opcode at the program counter. When that opcode is the call opcode (0x20), it fetches the low target byte and then uses the internal cycle. Next it pushes the return address onto the stack page, which is page one (0x0100 to 0x01FF). It then fetches the high target byte, loads the program counter with the target, and fetches the next opcode there. Any other opcode is treated as a one-byte step: the next cycle fetches the following address. Full instruction decode, arithmetic and flags are not part of the block.

A mode input selects how the internal cycle behaves. In the low-power-process ordering (`nmosMode` = 0), the internal cycle is a harmless read of the stack location, so peripherals never see a write they did not ask for. In the legacy ordering (`nmosMode` = 1), that cycle writes the just-fetched low target byte to the stack location. The next cycle then overwrites that location with the return-address high byte.

Top module: `subcall_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the opcode-fetch state: afterwards `addr` equals `resetPc`, `rnw` is 1, `sync` is 1, `done` is 0 and `stackPtr` equals `resetSp`.
- R2: An opcode other than 0x20, read in an opcode-fetch cycle, causes the next cycle to be another opcode fetch at that address plus 1 (mod 65536).
- R3: For the call opcode 0x20 fetched at address P with stack pointer S, the seven cycles drive `addr` P, P+1, 0x0100+S, 0x0100+S, 0x0100+((S-1) mod 256), P+2, target. `rnw` is 1, 1, mode-dependent, 0, 0, 1, 1. All address sums wrap mod 65536.
- R4: The return address pushed is P+2. Its high byte is written at 0x0100+S in cycle 4, and its low byte at 0x0100+S-1 (mod 256 within page one) in cycle 5.
- R5: With `nmosMode` = 0, cycle 3 is a read (`rnw` = 1) at 0x0100+S; no write occurs in that cycle.
- R6: With `nmosMode` = 1, cycle 3 is a write (`rnw` = 0) at 0x0100+S whose `wrData` equals the low target byte read in cycle 2.
- R7: The target is {byte read in cycle 6, byte read in cycle 2}. Cycle 7 fetches an opcode at that target with `sync` = 1.
- R8: When the call finishes, `stackPtr` equals S-2 mod 256.
- R9: `sync` is 1 only in opcode-fetch cycles. `done` is 1 for exactly one cycle, the high-target-byte read (cycle 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nmosMode | input | 1 | 1 selects the legacy ordering with a stack write in the internal cycle |
| resetPc | input | 16 | Program counter loaded on reset |
| resetSp | input | 8 | Stack pointer loaded on reset |
| rdData | input | 8 | Read data returned by memory for the current address |
| addr | output | 16 | Address driven in this cycle |
| wrData | output | 8 | Write data, valid when `rnw` is 0 |
| rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| sync | output | 1 | High during opcode-fetch cycles |
| done | output | 1 | One-cycle pulse in the final operand read of a call |
| stackPtr | output | 8 | Current stack pointer |

## Verification
The sweep crosses both orderings with stack pointers at 0x00, 0x01, 0x80, 0xB6 and 0xFF. It also uses opcode addresses that carry across the top of memory, so a design that failed to wrap the low push into 0x01FF, or the return address into 0x0000, would push to the wrong place. In the default ordering, a design that wrote in cycle 3 would corrupt an I/O location and flips `rnw`. In the legacy ordering, a design that left out that write, or stored the wrong byte, is caught on `wrData`. Cycles 7 and 8 check that the target is assembled from the right bytes and that a non-call opcode advances by one.

// File: rtl/subcall_pkg.sv
package subcall_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPLO,
    ST_INTERNAL,
    ST_PUSHHI,
    ST_PUSHLO,
    ST_OPHI
  } seqState_e;

  typedef enum logic {
    AS_PC,
    AS_STACK
  } addrSrc_e;

  typedef enum logic [1:0] {
    DS_NONE,
    DS_ADL,
    DS_PCH,
    DS_PCL
  } dataSrc_e;

  typedef struct packed {
    logic     pcInc;
    logic     pcLoadTarget;
    logic     latchLo;
    logic     spDec;
    logic     writeEn;
    addrSrc_e addrSrc;
    dataSrc_e dataSrc;
  } callStrobes_t;

endpackage

// File: rtl/subcall_ctrl.sv
module subcall_ctrl
  import subcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CALL_OPCODE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmosMode,
  input  logic [DATA_W-1:0] rdData,
  output callStrobes_t      strobes,
  output logic              sync,
  output logic              done
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_FETCH;
    else     stateQ <= stateD;
  end

  always_comb begin
    stateD               = stateQ;
    strobes              = '0;
    strobes.addrSrc      = AS_PC;
    strobes.dataSrc      = DS_NONE;
    sync                 = 1'b0;
    done                 = 1'b0;
    unique case (stateQ)
      ST_FETCH: begin
        sync          = 1'b1;
        strobes.pcInc = 1'b1;
        stateD        = (rdData == CALL_OPCODE) ? ST_OPLO : ST_FETCH;
      end
      ST_OPLO: begin
        strobes.pcInc   = 1'b1;
        strobes.latchLo = 1'b1;
        stateD          = ST_INTERNAL;
      end
      ST_INTERNAL: begin
        strobes.addrSrc = AS_STACK;
        if (nmosMode) begin
          strobes.writeEn = 1'b1;
          strobes.dataSrc = DS_ADL;
        end
        stateD = ST_PUSHHI;
      end
      ST_PUSHHI: begin
        strobes.addrSrc = AS_STACK;
        strobes.writeEn = 1'b1;
        strobes.dataSrc = DS_PCH;
        strobes.spDec   = 1'b1;
        stateD          = ST_PUSHLO;
      end
      ST_PUSHLO: begin
        strobes.addrSrc = AS_STACK;
        strobes.writeEn = 1'b1;
        strobes.dataSrc = DS_PCL;
        strobes.spDec   = 1'b1;
        stateD          = ST_OPHI;
      end
      ST_OPHI: begin
        strobes.pcLoadTarget = 1'b1;
        done                 = 1'b1;
        stateD               = ST_FETCH;
      end
      default: stateD = ST_FETCH;
    endcase
  end

  // R9
  done_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> sync);

  // R9
  sync_done_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(sync && done));

  // R5
  cmos_internal_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.latchLo) && !nmosMode) |-> !strobes.writeEn);

endmodule

// File: rtl/subcall_dp.sv
module subcall_dp
  import subcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] resetPc,
  input  logic [DATA_W-1:0] resetSp,
  input  logic [DATA_W-1:0] rdData,
  input  callStrobes_t      strobes,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              rnw,
  output logic [DATA_W-1:0] stackPtr
);

  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] spQ;
  logic [DATA_W-1:0] adlQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ  <= resetPc;
      spQ  <= resetSp;
      adlQ <= '0;
    end else begin
      if (strobes.pcLoadTarget) pcQ <= {rdData, adlQ};
      else if (strobes.pcInc)   pcQ <= pcQ + ADDR_W'(1);
      if (strobes.latchLo)      adlQ <= rdData;
      if (strobes.spDec)        spQ <= spQ - DATA_W'(1);
    end
  end

  always_comb begin
    addr = (strobes.addrSrc == AS_STACK) ? {STACK_PAGE, spQ} : pcQ;
    unique case (strobes.dataSrc)
      DS_ADL:  wrData = adlQ;
      DS_PCH:  wrData = pcQ[ADDR_W-1:DATA_W];
      DS_PCL:  wrData = pcQ[DATA_W-1:0];
      default: wrData = '0;
    endcase
    rnw      = !strobes.writeEn;
    stackPtr = spQ;
  end

  // R4
  write_in_stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    !rnw |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R4
  push_lo_below_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.dataSrc == DS_PCL) |-> addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]) - DATA_W'(1));

  // R8
  sp_two_below_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.pcLoadTarget |-> spQ == $past(spQ, 3) - DATA_W'(2));

  // R7
  target_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.pcLoadTarget) |-> addr == {$past(rdData), $past(adlQ)});

endmodule

// File: rtl/subcall_seq.sv
module subcall_seq
  import subcall_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CALL_OPCODE = 8'h20,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmosMode,
  input  logic [ADDR_W-1:0] resetPc,
  input  logic [DATA_W-1:0] resetSp,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              rnw,
  output logic              sync,
  output logic              done,
  output logic [DATA_W-1:0] stackPtr
);

  callStrobes_t strobes;

  subcall_ctrl #(
    .DATA_W(DATA_W),
    .CALL_OPCODE(CALL_OPCODE)
  ) i_ctrl (
    .clk(clk),
    .rst(rst),
    .nmosMode(nmosMode),
    .rdData(rdData),
    .strobes(strobes),
    .sync(sync),
    .done(done)
  );

  subcall_dp #(
    .DATA_W(DATA_W),
    .STACK_PAGE(STACK_PAGE)
  ) i_dp (
    .clk(clk),
    .rst(rst),
    .resetPc(resetPc),
    .resetSp(resetSp),
    .rdData(rdData),
    .strobes(strobes),
    .addr(addr),
    .wrData(wrData),
    .rnw(rnw),
    .stackPtr(stackPtr)
  );

  // R9
  fetch_is_read_chk: assert property (@(posedge clk) disable iff (rst)
    sync |-> rnw);

endmodule

// File: tb/test_subcall_seq.sv
module test_subcall_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmosMode = 1'b0;
  logic [15:0] resetPc = 16'h0000;
  logic [7:0]  resetSp = 8'hFF;
  logic [7:0]  rdData;
  logic [15:0] addr;
  logic [7:0]  wrData;
  logic        rnw;
  logic        sync;
  logic        done;
  logic [7:0]  stackPtr;

  logic [15:0] opAddr = 16'h0000;
  logic [7:0]  tgtLo = 8'h00;
  logic [7:0]  tgtHi = 8'h40;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model: call at opAddr, stack page patterned, 0xEA elsewhere
  always_comb begin
    if (addr == opAddr)                   rdData = 8'h20;
    else if (addr == 16'(opAddr + 16'd1)) rdData = tgtLo;
    else if (addr == 16'(opAddr + 16'd2)) rdData = tgtHi;
    else if (addr[15:8] == 8'h01)         rdData = addr[7:0] ^ 8'h5A;
    else                                  rdData = 8'hEA;
  end

  subcall_seq i_subcall_seq (
    .clk(clk), .rst(rst), .nmosMode(nmosMode), .resetPc(resetPc),
    .resetSp(resetSp), .rdData(rdData), .addr(addr), .wrData(wrData),
    .rnw(rnw), .sync(sync), .done(done), .stackPtr(stackPtr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h (mode %0d op %h sp %h)",
               req, what, act, exp, nmosMode, opAddr, resetSp);
    end
  endtask

  task automatic runCall(input logic mode, input logic [15:0] op, input logic [7:0] s);
    logic [15:0] ret;
    logic [15:0] tgt;
    nmosMode = mode;
    opAddr   = op;
    resetPc  = op;
    resetSp  = s;
    tgtLo    = 8'(op[7:0] + 8'h11);
    tgtHi    = op[15:8] ^ 8'h40;
    ret      = 16'(op + 16'd2);
    tgt      = {tgtHi, tgtLo};
    rst      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // cycle 1: opcode fetch right after reset (R1)
    chk("R1", "addr", addr, op);
    chk("R1", "rnw", rnw, 1);
    chk("R1", "sync", sync, 1);
    chk("R1", "done", done, 0);
    chk("R1", "stackPtr", stackPtr, s);
    rst = 1'b0;
    @(negedge clk);
    // cycle 2: low target byte read
    chk("R3", "c2 addr", addr, 16'(op + 16'd1));
    chk("R3", "c2 rnw", rnw, 1);
    chk("R9", "c2 sync", sync, 0);
    @(negedge clk);
    // cycle 3: internal cycle
    chk("R3", "c3 addr", addr, {8'h01, s});
    if (mode) begin
      chk("R6", "c3 rnw", rnw, 0);
      chk("R6", "c3 wrData", wrData, tgtLo);
    end else begin
      chk("R5", "c3 rnw", rnw, 1);
    end
    @(negedge clk);
    // cycle 4: push high byte of return address
    chk("R4", "c4 addr", addr, {8'h01, s});
    chk("R4", "c4 rnw", rnw, 0);
    chk("R4", "c4 wrData", wrData, ret[15:8]);
    @(negedge clk);
    // cycle 5: push low byte one location below
    chk("R4", "c5 addr", addr, {8'h01, 8'(s - 8'd1)});
    chk("R4", "c5 rnw", rnw, 0);
    chk("R4", "c5 wrData", wrData, ret[7:0]);
    @(negedge clk);
    // cycle 6: high target byte read, done pulse
    chk("R3", "c6 addr", addr, ret);
    chk("R3", "c6 rnw", rnw, 1);
    chk("R9", "c6 done", done, 1);
    chk("R9", "c6 sync", sync, 0);
    @(negedge clk);
    // cycle 7: next opcode at the target
    chk("R7", "c7 addr", addr, tgt);
    chk("R7", "c7 sync", sync, 1);
    chk("R9", "c7 done", done, 0);
    chk("R8", "c7 stackPtr", stackPtr, 8'(s - 8'd2));
    @(negedge clk);
    // cycle 8: non-call opcode steps by one
    chk("R2", "c8 addr", addr, 16'(tgt + 16'd1));
    chk("R2", "c8 sync", sync, 1);
    chk("R2", "c8 rnw", rnw, 1);
  endtask

  function automatic logic [15:0] opPick(int i);
    case (i)
      0: return 16'h802E;
      1: return 16'hFFFE;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'h1234;
    endcase
  endfunction

  function automatic logic [7:0] spPick(int i);
    case (i)
      0: return 8'hB6;
      1: return 8'h00;
      2: return 8'h01;
      3: return 8'hFF;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      for (int o = 0; o < 5; o++) begin
        for (int k = 0; k < 5; k++) begin
          runCall(m[0], opPick(o), spPick(k));
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule